// File: doc/BRIEF.md
# Serial Daisy-Chain Attenuator Control Register

This block is the control port for a pair of 65-step attenuator wipers. A host sends frames over three wires: an enable strobe, a serial clock and serial data. While the enable is high, each rising serial clock pushes one data bit into a 16-bit shift register, least significant bit first. The register's bit 0 is always visible on a cascade output. That output can drive the data input of the next device in a chain, so a chain of N devices takes 16×N clocks.

The shift register is the only store for the settings. When the enable falls, each 8-bit field is turned into a 7-bit wiper code, and a one-cycle strobe marks the pending update for the downstream gating logic. In each field, the low six bits select a position from 0 to 63, and the next bit up is a mute flag that forces code 64. The top bit of each field has no effect. The register keeps its contents after a load. If the cascade output is looped back to the data input, 16 clocks rotate the frame out for reading and return it to its starting place, and the following load changes nothing.

The serial inputs are sampled by a fast system clock. Serial clock edges and enable edges are detected on that clock, so every action happens on a system clock edge.

Top module: `wiper_chain_reg`

## Requirements
- R1: After reset, both wiper codes are 63, the register holds 0x3F3F, the cascade output is 1 and the update strobe is 0.
- R2: While the enable is high, each rising edge of the serial clock shifts the register one place toward bit 0, and the data bit enters at bit 15. A serial clock held high for several system cycles counts as one edge.
- R3: Serial clock edges while the enable is low change neither the register nor the cascade output.
- R4: The wiper codes change only in the system cycle that follows a falling enable. They hold steady while a frame is being shifted.
- R5: When its mute bit is clear, wiper 0 takes the code in bits 5:0 and wiper 1 takes the code in bits 13:8 (0 to 63). Wiper 0 appears on wiper_code[6:0] and wiper 1 on wiper_code[13:7].
- R6: A set mute bit (bit 6 for wiper 0, bit 14 for wiper 1) forces that wiper's code to 64, whatever its position bits hold.
- R7: Bits 7 and 15 have no effect on either wiper code.
- R8: The update strobe is high for exactly one cycle, together with the new codes, after each falling enable.
- R9: With the cascade output fed back to the data input, 16 clocks present bits 0 to 15 in order on the cascade output. After those 16 clocks the register holds its original value, and the load that follows leaves the codes unchanged.
- R10: A falling enable after fewer than 16 clocks loads whatever the register holds at that moment. No frame length check is made.
- R11: If a rising serial clock and a falling enable are sampled in the same cycle, no shift happens, and the load uses the register as it was before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Transfer enable; the falling edge loads the codes |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_cout | output | 1 | Cascade output, register bit 0 |
| wiper_code | output | 14 | Wiper codes 0..64: [6:0] wiper 0, [13:7] wiper 1 |
| wiper_upd | output | 1 | One-cycle strobe marking freshly loaded codes |

## Verification
The shift and the load can fall in the same sampled cycle. The bench provokes this by lowering the enable and raising the serial clock at one drive point after two bits of a frame. The codes that appear must decode the register as it stood before that edge, with the strobe high. A separate case holds the serial clock high across several cycles and confirms that only one shift took place, by loading and comparing against the bench's own register model.

// File: rtl/wiper_chain_pkg.sv
package wiper_chain_pkg;

  // Field geometry defaults shared by all submodules
  localparam int DEF_FIELD_W = 8;
  localparam int DEF_POS_W   = 6;

  // Kind of action decoded from the serial pins in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2
  } ser_act_e;

endpackage

// File: rtl/wcr_edge_ctl.sv
module wcr_edge_ctl
  import wiper_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ser_en,
  input  logic     ser_clk,
  output ser_act_e act
);

  logic en_q, en_d;
  logic sclk_q, sclk_d;

  // next state: remember last sampled pin levels
  always_comb begin
    en_d   = ser_en;
    sclk_d = ser_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sclk_q <= sclk_d;
    end
  end

  // Falling enable wins; shifting needs the enable high now
  always_comb begin
    if (en_q && !ser_en)
      act = ACT_LOAD;
    else if (ser_en && ser_clk && !sclk_q)
      act = ACT_SHIFT;
    else
      act = ACT_IDLE;
  end

endmodule

// File: rtl/wcr_shift_reg.sv
module wcr_shift_reg #(
  parameter int NUM_FIELDS = 2,
  parameter int FIELD_W    = 8,
  parameter int CTRL_W     = 7,
  parameter int RESET_POS  = 63,
  localparam int FRAME_W   = NUM_FIELDS * FIELD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic                         din,
  output logic                         cout,
  output logic [NUM_FIELDS*CTRL_W-1:0] ctrl_bits
);

  localparam logic [FIELD_W-1:0] FIELD_INIT = FIELD_W'(RESET_POS);
  localparam logic [FRAME_W-1:0] FRAME_INIT = {NUM_FIELDS{FIELD_INIT}};

  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en)
      sr_d = {din, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= FRAME_INIT;
    else        sr_q <= sr_d;
  end

  assign cout = sr_q[0];

  // hand out only the control bits of each field
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign ctrl_bits[f*CTRL_W +: CTRL_W] = sr_q[f*FIELD_W +: CTRL_W];
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[FRAME_W-1] == $past(din)) &&
                 (sr_q[FRAME_W-2:0] == $past(sr_q[FRAME_W-1:1])));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/wcr_wiper_slot.sv
module wcr_wiper_slot #(
  parameter int POS_W     = 6,
  parameter int RESET_POS = 63,
  localparam int CODE_W   = POS_W + 1,
  localparam logic [CODE_W-1:0] MUTE_CODE = CODE_W'(1) << POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [POS_W:0]    ctrl,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load_en)
      code_d = ctrl[POS_W] ? MUTE_CODE : {1'b0, ctrl[POS_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= CODE_W'(RESET_POS);
    else        code_q <= code_d;
  end

  assign code = code_q;

  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= MUTE_CODE);

  assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && ctrl[POS_W]) |=> (code_q == MUTE_CODE));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(code_q));

endmodule

// File: rtl/wiper_chain_reg.sv
module wiper_chain_reg
  import wiper_chain_pkg::*;
#(
  parameter int NUM_WIPERS = 2,
  parameter int FIELD_W    = DEF_FIELD_W,
  parameter int POS_W      = DEF_POS_W,
  parameter int RESET_POS  = 63,
  localparam int CODE_W    = POS_W + 1,
  localparam int CTRL_W    = POS_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_en,
  input  logic                         ser_clk,
  input  logic                         ser_din,
  output logic                         ser_cout,
  output logic [NUM_WIPERS*CODE_W-1:0] wiper_code,
  output logic                         wiper_upd
);

  ser_act_e                        act;
  logic                            shift_en, load_en;
  logic [NUM_WIPERS*CTRL_W-1:0]    ctrl_bits;
  logic                            upd_q, upd_d;

  wcr_edge_ctl u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_en  (ser_en),
    .ser_clk (ser_clk),
    .act     (act)
  );

  assign shift_en = (act == ACT_SHIFT);
  assign load_en  = (act == ACT_LOAD);

  wcr_shift_reg #(
    .NUM_FIELDS (NUM_WIPERS),
    .FIELD_W    (FIELD_W),
    .CTRL_W     (CTRL_W),
    .RESET_POS  (RESET_POS)
  ) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .din       (ser_din),
    .cout      (ser_cout),
    .ctrl_bits (ctrl_bits)
  );

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_wiper
    wcr_wiper_slot #(
      .POS_W     (POS_W),
      .RESET_POS (RESET_POS)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .ctrl    (ctrl_bits[w*CTRL_W +: CTRL_W]),
      .code    (wiper_code[w*CODE_W +: CODE_W])
    );
  end

  always_comb upd_d = load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_d;
  end

  assign wiper_upd = upd_q;

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_upd |=> !wiper_upd);

  assert_change_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_code) |-> wiper_upd);

endmodule

// File: tb/wiper_chain_reg_test.sv
module wiper_chain_reg_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_en, ser_clk, ser_din;
  logic        ser_cout;
  logic [13:0] wiper_code;
  logic        wiper_upd;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [15:0] model;

  always #4 clk = ~clk;

  wiper_chain_reg uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_en     (ser_en),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .ser_cout   (ser_cout),
    .wiper_code (wiper_code),
    .wiper_upd  (wiper_upd)
  );

  // {frame, expected wiper1, expected wiper0}
  localparam logic [29:0] VEC [9] = '{
    {16'h0000, 7'd0,  7'd0 },
    {16'h3F3F, 7'd63, 7'd63},
    {16'h1505, 7'd21, 7'd5 },
    {16'h4012, 7'd64, 7'd18},
    {16'h0747, 7'd7,  7'd64},
    {16'h8080, 7'd0,  7'd0 },   // R7
    {16'hFFFF, 7'd64, 7'd64},
    {16'hBF2A, 7'd63, 7'd42},   // R7
    {16'h7F7F, 7'd64, 7'd64}
  };

  function automatic logic [6:0] exp_code(input logic [7:0] fld);
    return fld[6] ? 7'd64 : {1'b0, fld[5:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    step();
    model = {b, model[15:1]};
    ser_clk = 1'b0;
    step();
  endtask

  task automatic load_and_check(input string req);
    ser_en = 1'b0;
    step();
    check(req, {18'd0, wiper_code}, {18'd0, exp_code(model[15:8]), exp_code(model[7:0])});
    check("R8", {31'd0, wiper_upd}, 32'd1);
    step();
    check("R8", {31'd0, wiper_upd}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ser_en = 1'b0; ser_clk = 1'b0; ser_din = 1'b0;
    model = 16'h3F3F;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1", {18'd0, wiper_code}, {18'd0, 7'd63, 7'd63});
    check("R1", {31'd0, ser_cout}, 32'd1);
    check("R1", {31'd0, wiper_upd}, 32'd0);

    // R3 clocks with enable low are ignored
    for (int i = 0; i < 4; i++) begin
      ser_din = 1'b0; ser_clk = 1'b1; step();
      ser_clk = 1'b0; step();
    end
    check("R3", {31'd0, ser_cout}, 32'd1);
    ser_en = 1'b1; step();
    load_and_check("R3");

    // vector table
    for (int v = 0; v < 9; v++) begin
      logic [15:0] fr;
      fr = VEC[v][29:14];
      ser_en = 1'b1; step();
      for (int b = 0; b < 16; b++) begin
        send_bit(fr[b]);
        if (b == 7) check("R4", {31'd0, wiper_upd}, 32'd0);
      end
      check("R4", {31'd0, wiper_upd}, 32'd0);
      ser_en = 1'b0; step();
      check("R5", {25'd0, wiper_code[6:0]},  {25'd0, VEC[v][6:0]});
      check("R6", {25'd0, wiper_code[13:7]}, {25'd0, VEC[v][13:7]});
      check("R8", {31'd0, wiper_upd}, 32'd1);
      step();
    end

    // R9 circular readback of 16'h7F7F
    begin
      logic [15:0] seen;
      ser_en = 1'b1; step();
      for (int b = 0; b < 16; b++) begin
        seen[b] = ser_cout;
        send_bit(ser_cout);
      end
      check("R9", {16'd0, seen}, {16'd0, 16'h7F7F});
      check("R9", {16'd0, model}, {16'd0, 16'h7F7F});
      load_and_check("R9");
      check("R9", {18'd0, wiper_code}, {18'd0, 7'd64, 7'd64});
    end

    // R2 held serial clock gives one shift
    ser_en = 1'b1; step();
    ser_din = 1'b0; ser_clk = 1'b1;
    step(); step(); step();
    model = {1'b0, model[15:1]};
    ser_clk = 1'b0; step();
    load_and_check("R2");
    check("R2", {18'd0, wiper_code}, {18'd0, 7'd63, 7'd63});

    // R10 partial frame
    ser_en = 1'b1; step();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    load_and_check("R10");

    // R11 rising clock and falling enable together
    ser_en = 1'b1; step();
    send_bit(1'b1); send_bit(1'b1);
    ser_din = 1'b0; ser_clk = 1'b1; ser_en = 1'b0;
    step();
    check("R11", {18'd0, wiper_code}, {18'd0, exp_code(model[15:8]), exp_code(model[7:0])});
    check("R11", {31'd0, wiper_upd}, 32'd1);
    check("R11", {31'd0, ser_cout}, {31'd0, model[0]});
    ser_clk = 1'b0; step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule